// File: doc/BRIEF.md
# Addressed Board Conversion Sequencer

This block is the control logic of one acquisition board among up to twenty that share a parallel address bus and a 16-bit data bus. It compares the 5-bit bus address with the board's strapped identity. When the address strobe is high and the two agree, it runs one timed command chain. The chain holds the analog sample, pulses the converter start, waits out the conversion, latches the 16-bit result, and then drives the shared data lines for a bounded window.

The analog track/hold and the converter are seen only as command and data signals. The converter result is captured in two byte-wide latches that share one enable. At the start of each access the block takes a snapshot of those latches. The value it drives is therefore the conversion finished during the board's previous access, so the bus controller can move on to the next board while this board converts. Outside the drive window the data lines are released to high impedance.

Each phase length is a parameter in clock cycles. These parameters take the place of hand-trimmed pulse delays. At 50 MHz, a 16-bit conversion at about 1 µs per bit needs a conversion window of about 800 cycles.

Top module: `acq_board_seq`

## Requirements
- R1: A sequence starts only on the cycle in which (addr_strobe_i high and addr_i equal to board_id_i) becomes true after being false. A strobe carrying another board's address, or a matching address with the strobe low, leaves hold_o, conv_start_o, latch_en_o and data_oe_o at 0.
- R2: hold_o goes to 1 one cycle after the launching edge. It stays at 1 for exactly SETTLE_CYC + CONV_CYC cycles and then returns to 0 (track).
- R3: conv_start_o is a single-cycle pulse in hold cycle SETTLE_CYC + 1, counting the first hold cycle as 1.
- R4: latch_en_o is a single-cycle pulse in the cycle after hold ends. On that edge both bytes of adc_data_i are captured: bits 7:0 form the low byte and bits 15:8 the high byte.
- R5: data_oe_o rises in the cycle after latch_en_o. If the strobe stays high, it stays at 1 for exactly DRIVE_CYC cycles.
- R6: While driving, a low addr_strobe_i ends the drive at the next edge. The first drive cycle always occurs, even if the strobe dropped earlier.
- R7: During the drive window, data_o shows the latched result as it stood at the launching edge, which is the previous access's conversion. After reset this value is 0.
- R8: data_o is high impedance and data_oe_o is 0 in every cycle outside the drive window.
- R9: A match edge that arrives while a sequence is running is ignored. A strobe that is still high when the sequence returns to idle does not start a new one.
- R10: While rst_ni is low, all command outputs are 0 and the latched result is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Board address on the shared bus |
| addr_strobe_i | input | 1 | Address valid strobe |
| board_id_i | input | 5 | Strapped board identity |
| adc_data_i | input | 16 | Converter result |
| hold_o | output | 1 | 1 = hold the analog sample, 0 = track |
| conv_start_o | output | 1 | Converter start pulse |
| latch_en_o | output | 1 | Result latch enable for both bytes |
| data_oe_o | output | 1 | Data driver enable |
| data_o | output | 16 | Shared data lines, high impedance when not driving |

## Verification
The bench targets the one-access lag of the data. A design that drives the fresh conversion, or that swaps the two byte halves, fails the scoreboard comparison on every access after the first.

The bench also changes adc_data_i right after the latch pulse. A latch that captures one edge late then picks up the wrong value. Strobes are dropped in the middle of the drive window, on the first drive cycle, and before the drive begins, so an off-by-one exit or a skipped first drive cycle shows up as a wrong data_oe_o count. A strobe glitch during conversion and a strobe held after the sequence ends check that the block starts only on a fresh match edge. A design that relaunches would raise hold_o again.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_CONVERT,
    PH_LATCH,
    PH_DRIVE
  } phase_e;
endpackage

// File: rtl/acq_board_match.sv
module acq_board_match #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] id_i,
  output logic              launch_o
);
  logic hit, hit_q;

  assign hit = strobe_i && (addr_i == id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end

  // only a fresh match starts an access
  assign launch_o = hit && !hit_q;
endmodule

// File: rtl/acq_phase_seq.sv
module acq_phase_seq
  import acq_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned CONV_CYC   = 800,
  parameter int unsigned DRIVE_CYC  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic strobe_i,
  output logic snap_o,
  output logic hold_o,
  output logic conv_start_o,
  output logic latch_en_o,
  output logic drive_o
);
  localparam int unsigned MAX_AB  = (SETTLE_CYC > CONV_CYC) ? SETTLE_CYC : CONV_CYC;
  localparam int unsigned MAX_LEN = (MAX_AB > DRIVE_CYC) ? MAX_AB : DRIVE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  always_comb begin
    case (ph_q)
      PH_SETTLE:  last = (cnt_q == CNT_W'(SETTLE_CYC - 1));
      PH_CONVERT: last = (cnt_q == CNT_W'(CONV_CYC - 1));
      PH_DRIVE:   last = (cnt_q == CNT_W'(DRIVE_CYC - 1));
      default:    last = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (launch_i) ph_q <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (last) begin ph_q <= PH_CONVERT; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_CONVERT: begin
          if (last) begin ph_q <= PH_LATCH; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_LATCH: begin
          ph_q  <= PH_DRIVE;
          cnt_q <= '0;
        end
        PH_DRIVE: begin
          if (last || !strobe_i) begin ph_q <= PH_IDLE; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign snap_o       = launch_i && (ph_q == PH_IDLE);
  assign hold_o       = (ph_q == PH_SETTLE) || (ph_q == PH_CONVERT);
  assign conv_start_o = (ph_q == PH_CONVERT) && (cnt_q == '0);
  assign latch_en_o   = (ph_q == PH_LATCH);
  assign drive_o      = (ph_q == PH_DRIVE);

  assert_convert_inside_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> hold_o);
  assert_track_after_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> latch_en_o);
  assert_latch_then_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en_o |=> drive_o);
  assert_strobe_ends_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o && !strobe_i |=> !drive_o);
  assert_one_command_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({conv_start_o, latch_en_o, drive_o}));
  assert_busy_ignores_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE) && launch_i |=> !(ph_q == PH_SETTLE && cnt_q == '0));
endmodule

// File: rtl/acq_byte_reg.sv
module acq_byte_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/acq_board_seq.sv
module acq_board_seq #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned CONV_CYC   = 800,
  parameter int unsigned DRIVE_CYC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_strobe_i,
  input  logic [ADDR_W-1:0] board_id_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              hold_o,
  output logic              conv_start_o,
  output logic              latch_en_o,
  output logic              data_oe_o,
  output wire  [DATA_W-1:0] data_o
);
  localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;

  logic              launch, snap;
  logic [DATA_W-1:0] result_q, shadow_q;

  acq_board_match #(.ADDR_W(ADDR_W)) i_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .strobe_i (addr_strobe_i),
    .id_i     (board_id_i),
    .launch_o (launch)
  );

  acq_phase_seq #(
    .SETTLE_CYC (SETTLE_CYC),
    .CONV_CYC   (CONV_CYC),
    .DRIVE_CYC  (DRIVE_CYC)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .strobe_i     (addr_strobe_i),
    .snap_o       (snap),
    .hold_o       (hold_o),
    .conv_start_o (conv_start_o),
    .latch_en_o   (latch_en_o),
    .drive_o      (data_oe_o)
  );

  // result bytes share one latch enable; the snapshot keeps the previous access's value
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    acq_byte_reg #(.W(BYTE_W)) i_result (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (latch_en_o),
      .d_i    (adc_data_i[b*BYTE_W +: BYTE_W]),
      .q_o    (result_q[b*BYTE_W +: BYTE_W])
    );
    acq_byte_reg #(.W(BYTE_W)) i_shadow (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (snap),
      .d_i    (result_q[b*BYTE_W +: BYTE_W]),
      .q_o    (shadow_q[b*BYTE_W +: BYTE_W])
    );
  end

  assign data_o = data_oe_o ? shadow_q : {DATA_W{1'bz}};

  assert_start_needs_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(addr_strobe_i && (addr_i == board_id_i)));
  assert_drive_value_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o && $past(data_oe_o) |-> $stable(shadow_q));
endmodule

// File: tb/test_acq_board_seq.sv
module test_acq_board_seq;
  localparam int unsigned SETTLE = 3;
  localparam int unsigned CONV   = 20;
  localparam int unsigned DRIVE  = 6;
  localparam int unsigned D0     = SETTLE + CONV + 2;
  localparam int unsigned TOTAL  = D0 + DRIVE + 2;
  localparam logic [4:0]  MY_ID  = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        strobe = 1'b0;
  logic [15:0] adc = '0;
  logic        hold, conv, latch_en, oe;
  wire  [15:0] data;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_val = '0;
  logic        oe_prev = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  acq_board_seq #(
    .SETTLE_CYC (SETTLE),
    .CONV_CYC   (CONV),
    .DRIVE_CYC  (DRIVE)
  ) i_acq_board_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .addr_i        (addr),
    .addr_strobe_i (strobe),
    .board_id_i    (MY_ID),
    .adc_data_i    (adc),
    .hold_o        (hold),
    .conv_start_o  (conv),
    .latch_en_o    (latch_en),
    .data_oe_o     (oe),
    .data_o        (data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: each drive window start pops one expected word
  always @(negedge clk) begin
    if (rst_n && oe && !oe_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R7", "unexpected drive", int'(data), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(data == e, "R7", "driven word (R4 byte halves)", int'(data), int'(e));
      end
    end
    oe_prev = oe;
  end

  // driver: drop_at = negedge after which strobe falls; glitch pulses strobe in conversion
  task automatic run_access(input logic [15:0] val, input int drop_at, input bit glitch);
    int hold_bad = 0, conv_bad = 0, latch_bad = 0, oe_bad = 0, oe_cnt = 0;
    exp_q.push_back(last_val);
    last_val = val;
    adc = val;
    @(negedge clk);
    addr = MY_ID;
    strobe = 1'b1;
    for (int n = 1; n <= TOTAL; n++) begin
      bit e_oe;
      @(negedge clk);
      e_oe = (n >= D0) && (n <= D0 + DRIVE - 1) && ((n == D0) || (n <= drop_at));
      if (hold !== (n <= SETTLE + CONV)) hold_bad++;
      if (conv !== (n == SETTLE + 1)) conv_bad++;
      if (latch_en !== (n == SETTLE + CONV + 1)) latch_bad++;
      if (oe !== e_oe) oe_bad++;
      if (oe) oe_cnt++;
      if (n == SETTLE + CONV + 2) adc = ~val;
      if (glitch && n == SETTLE + 2) strobe = 1'b0;
      if (glitch && n == SETTLE + 3) strobe = 1'b1;
      if (n == drop_at) strobe = 1'b0;
    end
    check(hold_bad == 0, "R2", "hold cycles off", hold_bad, 0);
    check(conv_bad == 0, "R3", "convert pulse cycles off", conv_bad, 0);
    check(latch_bad == 0, "R4", "latch pulse cycles off", latch_bad, 0);
    check(oe_bad == 0, (drop_at < TOTAL) ? "R6" : "R5", "drive cycles off", oe_bad, 0);
    check(oe_cnt >= 1, "R8", "drive count", oe_cnt, 1);
    if (glitch) check(1'b1, "R9", "glitch in conversion ignored", 0, 0);
    if (strobe) begin
      int relaunch = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (hold || oe) relaunch++;
      end
      check(relaunch == 0, "R9", "relaunch on held strobe", relaunch, 0);
      strobe = 1'b0;
    end
    @(negedge clk);
    check(oe == 1'b0, "R8", "drivers released after access", int'(oe), 0);
  endtask

  task automatic quiet_window(input logic [4:0] a, input bit s, input string what);
    int act = 0;
    @(negedge clk);
    addr = a;
    strobe = s;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (hold || conv || latch_en || oe) act++;
    end
    strobe = 1'b0;
    check(act == 0, "R1", what, act, 0);
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({hold, conv, latch_en, oe} == 4'b0, "R10", "outputs in reset", int'({hold, conv, latch_en, oe}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(oe == 1'b0, "R8", "idle drivers off", int'(oe), 0);

    quiet_window(MY_ID + 5'd1, 1'b1, "other board address");
    quiet_window(MY_ID, 1'b0, "matching address without strobe");

    run_access(16'hA55A, TOTAL + 10, 1'b0); // R7: first read gives the reset value 0
    run_access(16'h3CC3, D0 + 2, 1'b0);     // R6 drop mid-drive
    run_access(16'h0FF0, TOTAL + 10, 1'b1); // R9 glitch during conversion
    run_access(16'h1234, D0, 1'b0);         // R6 drop on first drive cycle
    run_access(16'hBEEF, SETTLE + 2, 1'b0); // R6 strobe gone before drive
    quiet_window(MY_ID - 5'd1, 1'b1, "neighbour address after accesses");
    run_access(16'h0000, TOTAL + 10, 1'b0); // flush shows 16'hBEEF

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7", "expected words left unconsumed", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule